// File: doc/BRIEF.md
# Aliased Push/Pop Queue Window

This block presents a pair of 64-bit word queues behind a simple register bus. Every address in the lower half of the address space forms a single queue window. A write to any offset in that window appends the write data to the ingress queue. A read from any offset in the window takes the oldest word from the egress queue. Between the two queues, a loopback mover takes one word per cycle from ingress to egress. Every accepted word therefore leaves the block exactly once, and in the order it was written.

Software that misuses the queues is reported rather than silently ignored. A write is dropped when the ingress queue is full, and this sets a sticky overflow flag. A read is answered with zero when the egress queue is empty, and this sets a sticky underflow flag. Each flag is cleared by writing 1 to its bit in a status register that lies outside the window. A mask register enables each flag onto a single interrupt line. The status register also shows the full and empty state of both queues, and these bits are read-only.

Top module: `qwin_top`

## Requirements
- R1: After reset, both queues are empty, both sticky flags and both mask bits are 0, and `irqOut` is 0. A status read then returns 0x28.
- R2: A write with `busAddr` in 0x00–0x7F pushes `busWdata` onto the ingress queue, whatever the offset within the window.
- R3: A read with `busAddr` in 0x00–0x7F pops the egress queue, whatever the offset. The popped word appears on `busRdata` at the clock edge that samples the read, and stays there until the next read.
- R4: Every accepted word is read out exactly once, in write order. Up to 32 words can be held in total (16 in each queue), and the loopback moves one word per cycle whenever ingress is not empty and egress is not full.
- R5: A window write while the ingress queue is full is discarded and sets the overflow flag, which is status bit 0.
- R6: A window read while the egress queue is empty returns zero and sets the underflow flag, which is status bit 1.
- R7: The status register is at 0x80. The flags stay set until a write to 0x80 with a 1 in the flag's bit position. A write of 0 leaves a flag unchanged. If a flag is set and cleared in the same cycle, the set wins.
- R8: Status bits 2..5 give ingress full, ingress empty, egress full and egress empty, in that order. Writes do not change them.
- R9: The mask register is at 0x88. Bit 0 enables overflow and bit 1 enables underflow. `irqOut` is high when any flag is set and its mask bit is 1. A mask read returns the two bits.
- R10: An access to any other address outside the window reads as zero. It pushes nothing, pops nothing and changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Register bus address |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe |
| busWdata | input | 64 | Write data |
| busRdata | output | 64 | Registered read data |
| irqOut | output | 1 | Masked OR of the sticky flags |

## Verification
The bench goes after the boundary at 32 stored words. A design that counted the capacity wrongly would either drop the 32nd word or accept the 33rd, and the drained sequence would show it. It also pops past the last word. Here a faulty design would return stale data instead of zero, or would leave the underflow flag clear. The clear-on-write tests use zero writes, single-bit writes and writes to the read-only bits. These catch flags that clear on any write, or full and empty bits that can be overwritten. Window accesses at scattered offsets are mixed with accesses to unmapped addresses. This exposes any decode that either misses part of the window or lets an unmapped access push or pop.

// File: rtl/qwin_pkg.sv
package qwin_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
  } qwinStrobe_t;

  // Queue state from datapath to control
  typedef struct packed {
    logic inFull;
    logic inEmpty;
    logic outFull;
    logic outEmpty;
  } qwinLevel_t;

endpackage

// File: rtl/qwin_fifo.sv
module qwin_fifo #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushEn,
  input  logic [DATA_W-1:0] pushData,
  input  logic              popEn,
  output logic [DATA_W-1:0] headData,
  output logic              full,
  output logic              empty,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  cnt;
  logic              doPush, doPop;

  assign full   = (cnt == CNT_W'(DEPTH));
  assign empty  = (cnt == '0);
  assign doPush = pushEn && !full;
  assign doPop  = popEn && !empty;
  assign headData = mem[rdPtr];
  assign count  = cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else begin
      if (doPush) begin
        wrPtr <= (wrPtr == PTR_W'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      end
      if (doPop) begin
        rdPtr <= (rdPtr == PTR_W'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
      end
      if (doPush && !doPop)      cnt <= cnt + 1'b1;
      else if (doPop && !doPush) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  // R5: a push into a full queue never raises the occupancy
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && full) |=> (cnt <= $past(cnt)));

  // R6: a pop from an empty queue never lowers the occupancy
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    (popEn && empty) |=> (cnt >= $past(cnt)));

endmodule

// File: rtl/qwin_dpath.sv
module qwin_dpath
  import qwin_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  qwinStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] outHead,
  output qwinLevel_t        level
);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [DATA_W-1:0] inHead;
  logic              inFull, inEmpty, outFull, outEmpty, move;
  logic [CNT_W-1:0]  inCount, outCount;

  // Loopback mover: one word per cycle
  assign move = !inEmpty && !outFull;

  qwin_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uIngress (
    .clk(clk), .rstN(rstN),
    .pushEn(strobe.push), .pushData(wrData),
    .popEn(move), .headData(inHead),
    .full(inFull), .empty(inEmpty), .count(inCount)
  );

  qwin_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uEgress (
    .clk(clk), .rstN(rstN),
    .pushEn(move), .pushData(inHead),
    .popEn(strobe.pop), .headData(outHead),
    .full(outFull), .empty(outEmpty), .count(outCount)
  );

  assign level = '{inFull: inFull, inEmpty: inEmpty,
                   outFull: outFull, outEmpty: outEmpty};

  // R4: the total held changes only by accepted pushes and pops
  a_r4_conserve: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (int'(inCount) + int'(outCount)) ==
             (int'($past(inCount)) + int'($past(outCount))
              + int'($past(strobe.push && !inFull))
              - int'($past(strobe.pop && !outEmpty))));

  // R4: words never sit in ingress while egress has room
  a_r4_mover_runs: assert property (@(posedge clk) disable iff (!rstN)
    (!inEmpty && !outFull && !strobe.pop) |=> (outCount == $past(outCount) + 1'b1));

endmodule

// File: rtl/qwin_ctrl.sv
module qwin_ctrl
  import qwin_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [1:0]        wrLow,
  input  logic [DATA_W-1:0] outHead,
  input  qwinLevel_t        level,
  output qwinStrobe_t       strobe,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(1) << (ADDR_W-1);
  localparam logic [ADDR_W-1:0] MASK_ADDR = STAT_ADDR + ADDR_W'(8);

  logic       inWin, statSel, maskSel, statWr, maskWr;
  logic       ovfQ, udfQ;
  logic [1:0] maskQ;
  logic [DATA_W-1:0] rdNext, rdQ;

  assign inWin   = !busAddr[ADDR_W-1];
  assign statSel = (busAddr == STAT_ADDR);
  assign maskSel = (busAddr == MASK_ADDR);
  assign statWr  = busWe && statSel;
  assign maskWr  = busWe && maskSel;

  assign strobe.push = busWe && inWin;
  assign strobe.pop  = busRe && inWin;

  always_comb begin
    rdNext = '0;
    if (inWin) begin
      rdNext = level.outEmpty ? '0 : outHead;
    end else if (statSel) begin
      rdNext = {{(DATA_W-6){1'b0}}, level.outEmpty, level.outFull,
                level.inEmpty, level.inFull, udfQ, ovfQ};
    end else if (maskSel) begin
      rdNext = {{(DATA_W-2){1'b0}}, maskQ};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfQ  <= 1'b0;
      udfQ  <= 1'b0;
      maskQ <= 2'b00;
      rdQ   <= '0;
    end else begin
      ovfQ <= (ovfQ && !(statWr && wrLow[0])) || (strobe.push && level.inFull);
      udfQ <= (udfQ && !(statWr && wrLow[1])) || (strobe.pop && level.outEmpty);
      if (maskWr) maskQ <= wrLow;
      if (busRe)  rdQ   <= rdNext;
    end
  end

  assign busRdata = rdQ;
  assign irqOut   = (ovfQ && maskQ[0]) || (udfQ && maskQ[1]);

  // R7: a set flag holds unless its clear bit is written
  a_r7_sticky_ovf: assert property (@(posedge clk) disable iff (!rstN)
    (ovfQ && !(statWr && wrLow[0])) |=> ovfQ);
  a_r7_sticky_udf: assert property (@(posedge clk) disable iff (!rstN)
    (udfQ && !(statWr && wrLow[1])) |=> udfQ);

  // R5 / R6: misuse always raises the flag
  a_r5_ovf_raised: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && inWin && level.inFull) |=> ovfQ);
  a_r6_udf_raised: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && inWin && level.outEmpty) |=> (udfQ && busRdata == '0));

  // R10: unmapped accesses never reach the queues
  a_r10_no_stray: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[ADDR_W-1]) |-> !(strobe.push || strobe.pop));

endmodule

// File: rtl/qwin_top.sv
module qwin_top
  import qwin_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);
  qwinStrobe_t       strobe;
  qwinLevel_t        level;
  logic [DATA_W-1:0] outHead;

  qwin_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .wrLow(busWdata[1:0]), .outHead(outHead), .level(level),
    .strobe(strobe), .busRdata(busRdata), .irqOut(irqOut)
  );

  qwin_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uDpath (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .wrData(busWdata),
    .outHead(outHead), .level(level)
  );

endmodule

// File: tb/tb_qwin_top.sv
module tb_qwin_top;
  localparam int CLK_PERIOD = 10;
  localparam int CAP = 32;
  localparam int HALF = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [63:0] busWdata = '0;
  logic [63:0] busRdata;
  logic        irqOut;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [63:0] model[$];
  logic expOvf = 0, expUdf = 0;
  logic [1:0] expMask = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qwin_top dut (.clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
                .busRe(busRe), .busWdata(busWdata), .busRdata(busRdata),
                .irqOut(irqOut));

  function automatic logic [63:0] statExp(int n, logic ovf, logic udf);
    int oc = (n > HALF) ? HALF : n;
    int ic = n - oc;
    return {58'b0, oc == 0, oc == HALF, ic == 0, ic == HALF, udf, ovf};
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(logic [7:0] a, logic [63:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(logic [7:0] a, output logic [63:0] d);
    busAddr = a; busRe = 1'b1;
    @(negedge clk);
    busRe = 1'b0;
    d = busRdata;
  endtask

  task automatic pushWord(logic [7:0] a, logic [63:0] d);
    busWrite(a, d);
    if (model.size() < CAP) model.push_back(d);
    else expOvf = 1'b1;
    idle(2);
  endtask

  task automatic popCheck(logic [7:0] a, string req);
    logic [63:0] got, exp;
    busRead(a, got);
    if (model.size() > 0) exp = model.pop_front();
    else begin exp = '0; expUdf = 1'b1; end
    check(req, got, exp);
    idle(2);
  endtask

  task automatic statCheck(string req);
    logic [63:0] got;
    busRead(8'h80, got);
    check(req, got, statExp(model.size(), expOvf, expUdf));
  endtask

  function automatic logic irqExp();
    return (expOvf && expMask[0]) || (expUdf && expMask[1]);
  endfunction

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [63:0] got;
    void'($urandom(32'h5eed1234));
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1: reset state
    check("R1 irq", {63'b0, irqOut}, 64'h0);
    check("R1 rdata", busRdata, 64'h0);
    busRead(8'h80, got);
    check("R1 status", got, 64'h28);
    busRead(8'h88, got);
    check("R1 mask", got, 64'h0);

    // R2 R3 R4: random window traffic
    for (int i = 0; i < 60; i++) begin
      logic [7:0] a = 8'($urandom_range(0, 127));
      if (($urandom_range(0, 9) < 6) || model.size() == 0)
        pushWord(a, {$urandom, $urandom});
      else
        popCheck(a, "R3 random pop");
    end
    statCheck("R8 status after random");
    while (model.size() > 0) popCheck(8'($urandom_range(0, 127)), "R4 drain order");
    expUdf = 1'b0; expOvf = 1'b0;
    busWrite(8'h80, 64'h3);
    statCheck("R7 clear both");

    // R5: fill to capacity and beyond
    for (int i = 0; i < CAP + 3; i++) pushWord(8'(i * 3), 64'hA5A5_0000_0000_0000 | 64'(i));
    check("R5 stored count", 64'(model.size()), 64'(CAP));
    statCheck("R5 R8 full status");

    // R10: unmapped access touches nothing
    busWrite(8'h90, 64'hFFFF);
    idle(2);
    busRead(8'h90, got);
    check("R10 unmapped read", got, 64'h0);
    statCheck("R10 state unchanged");

    // R9: irq masking
    check("R9 irq masked off", {63'b0, irqOut}, 64'h0);
    busWrite(8'h88, 64'h2); expMask = 2'b10;
    check("R9 irq udf only", {63'b0, irqOut}, {63'b0, irqExp()});
    busWrite(8'h88, 64'h1); expMask = 2'b01;
    check("R9 irq ovf enabled", {63'b0, irqOut}, {63'b0, irqExp()});
    busRead(8'h88, got);
    check("R9 mask readback", got, 64'h1);

    // R7 R8: zero writes and read-only bits
    busWrite(8'h80, 64'h0);
    statCheck("R7 write zero keeps flag");
    busWrite(8'h80, 64'h3C);
    statCheck("R8 read-only bits kept");

    // R4 R6: drain all then over-read
    while (model.size() > 0) popCheck(8'($urandom_range(0, 127)), "R4 full drain");
    popCheck(8'h7F, "R6 empty read zero");
    statCheck("R6 underflow flag");
    check("R9 irq ovf still", {63'b0, irqOut}, {63'b0, irqExp()});

    // R7: clear only overflow
    busWrite(8'h80, 64'h1); expOvf = 1'b0;
    statCheck("R7 clear ovf only");
    check("R9 irq after clear", {63'b0, irqOut}, {63'b0, irqExp()});
    busWrite(8'h88, 64'h3); expMask = 2'b11;
    check("R9 irq udf enabled", {63'b0, irqOut}, {63'b0, irqExp()});
    busWrite(8'h80, 64'h2); expUdf = 1'b0;
    statCheck("R7 clear udf");
    check("R9 irq low", {63'b0, irqOut}, 64'h0);

    // R2 R3: edge offsets
    pushWord(8'h7F, 64'h1122_3344_5566_7788);
    pushWord(8'h00, 64'h99AA_BBCC_DDEE_FF00);
    popCheck(8'h40, "R3 first");
    popCheck(8'h01, "R2 second");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule